// File: doc/BRIEF.md
# Three-Button Mouse Packet Encoder

This block turns one mouse motion event into a fixed five-byte packet and queues the bytes in an on-chip byte FIFO. An event carries a signed horizontal step, a signed vertical step and the state of the left, middle and right buttons. The encoder builds a header byte from the buttons, saturates both motion values to the symmetric range -127..+127 (the vertical value is negated first), appends two zero bytes and pushes the five bytes, one per clock, into the FIFO.

A consumer drains the FIFO through a show-ahead read port: the head byte is always visible on the data output while the not-empty flag is high, and a read strobe pops it. An event is taken only when the encoder is idle and at least five FIFO slots are free. Otherwise it is refused and a reject flag pulses, so a packet is never split or partly lost.

Top module: `mspkt_encoder`

## Requirements
- R1: The first byte of a packet is 0x87 with bit 2 cleared when the left button is pressed, bit 1 cleared for the middle button and bit 0 cleared for the right button; bits 7..3 are always 1,0,0,0,0.
- R2: The second byte is the horizontal step saturated to -127..+127, in two's complement (e.g. +200 gives 0x7F, -300 and -128 give 0x81).
- R3: The third byte is the negated vertical step saturated to -127..+127; the most negative input values (-128, -512) give 0x7F, and +127 gives 0x81.
- R4: The fourth and fifth bytes of every packet are 0x00.
- R5: Bytes leave the FIFO in the order pushed. Packets leave in the order their events were accepted. `rd_data` shows the head byte while `rd_nonempty` is 1. A read strobe while empty changes nothing.
- R6: An accepted event makes `busy` high for exactly five cycles, starting the cycle after the event. One byte is pushed in each of those cycles.
- R7: An event is accepted only when `busy` is low and at least five FIFO slots are free. Otherwise `evt_reject` is high in the following cycle and the event adds no byte.
- R8: The FIFO holds FIFO_DEPTH bytes. With the default depth of 256, 51 packets fill 255 slots. A further event is refused until a fifth slot frees.
- R9: After reset `busy`, `evt_reject` and `rd_nonempty` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event strobe, one cycle per event |
| evt_dx | input | MOT_W | Horizontal step, two's complement |
| evt_dy | input | MOT_W | Vertical step, two's complement |
| btn_left | input | 1 | Left button pressed |
| btn_middle | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| evt_reject | output | 1 | Event of the previous cycle was refused |
| busy | output | 1 | Packet bytes are being pushed |
| rd_en | input | 1 | Pop the head byte |
| rd_data | output | 8 | Head byte of the FIFO |
| rd_nonempty | output | 1 | FIFO holds at least one byte |

## Verification
The hardest state to reach is the space boundary. The FIFO must sit exactly one slot short of a packet, at four free slots, and then gain the fifth. The stimulus reaches it with 51 back-to-back packets and no reads. It then pops three bytes and shows a refusal, and pops one more and shows acceptance. Constrained-random phases that alternate between sparse and heavy reading bring the FIFO near full many times, while a cycle-level reference model in the bench checks every output.

// File: rtl/mspkt_pkg.sv
package mspkt_pkg;

   localparam int PKT_BYTES = 5;
   localparam int SLOT_W    = $clog2(PKT_BYTES + 1);

   typedef logic [7:0] byte_t;

   localparam byte_t HDR_BASE = 8'h87;

   typedef struct packed {
      byte_t hdr;
      byte_t mx;
      byte_t my;
   } pkt_t;

endpackage

// File: rtl/mspkt_sat.sv
module mspkt_sat
   import mspkt_pkg::*;
#(
   parameter int IN_W   = 10,
   parameter bit NEGATE = 1'b0
) (
   input  logic [IN_W-1:0] raw,
   output byte_t           sat
);

   localparam logic signed [IN_W:0] LIM_HI = (IN_W+1)'(127);
   localparam logic signed [IN_W:0] LIM_LO = -LIM_HI;

   logic signed [IN_W:0] wide;

   generate
      if (NEGATE) begin : g_neg
         assign wide = -$signed({raw[IN_W-1], raw});
      end else begin : g_pass
         assign wide = $signed({raw[IN_W-1], raw});
      end
   endgenerate

   always_comb begin
      if (wide > LIM_HI) begin
         sat = 8'h7F;
      end else if (wide < LIM_LO) begin
         sat = 8'h81;
      end else begin
         sat = wide[7:0];
      end
   end

endmodule

// File: rtl/mspkt_seq.sv
module mspkt_seq
   import mspkt_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load,
   input  pkt_t  pkt_in,
   output logic  busy,
   output logic  push,
   output byte_t push_byte
);

   pkt_t              pkt_q;
   logic [SLOT_W-1:0] remain;
   logic [SLOT_W-1:0] slot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain <= '0;
         pkt_q  <= '0;
      end else if (load) begin
         remain <= SLOT_W'(PKT_BYTES);
         pkt_q  <= pkt_in;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end
   end

   assign busy = (remain != '0);
   assign push = busy;
   assign slot = SLOT_W'(PKT_BYTES) - remain;

   always_comb begin
      case (slot)
         SLOT_W'(0): push_byte = pkt_q.hdr;
         SLOT_W'(1): push_byte = pkt_q.mx;
         SLOT_W'(2): push_byte = pkt_q.my;
         default:    push_byte = 8'h00;
      endcase
   end

   a_r6_five_beats : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |=> busy ##1 busy ##1 busy ##1 busy ##1 !busy);

   a_r6_no_load_busy : assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !load);

   a_r1_hdr_form : assert property (@(posedge clk) disable iff (!rst_n)
      (push && slot == SLOT_W'(0)) |-> push_byte[7:3] == 5'b10000);

   a_r2_no_minus128 : assert property (@(posedge clk) disable iff (!rst_n)
      (push && (slot == SLOT_W'(1) || slot == SLOT_W'(2))) |-> push_byte != 8'h80);

endmodule

// File: rtl/mspkt_fifo.sv
module mspkt_fifo
   import mspkt_pkg::*;
#(
   parameter int DEPTH = 256
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  byte_t                      wdata,
   input  logic                       pop,
   output byte_t                      rdata,
   output logic                       nonempty,
   output logic [$clog2(DEPTH+1)-1:0] free_slots
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

   byte_t           mem [DEPTH];
   logic [AW-1:0]   wptr, rptr, wptr_nx, rptr_nx;
   logic [CW-1:0]   count;
   logic            full, do_push, do_pop;

   assign full     = (count == DEPTH_C);
   assign nonempty = (count != '0);
   assign do_push  = push && !full;
   assign do_pop   = pop && nonempty;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_wrap
         assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wptr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr_nx;
         if (do_pop)  rptr <= rptr_nx;
         if (do_push && !do_pop) begin
            count <= count + 1'b1;
         end else if (do_pop && !do_push) begin
            count <= count - 1'b1;
         end
      end
   end

   assign rdata      = mem[rptr];
   assign free_slots = DEPTH_C - count;

   a_r8_count_bound : assert property (@(posedge clk) disable iff (!rst_n)
      count <= DEPTH_C);

   a_r8_full_drop : assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> count == $past(count));

   a_r5_empty_pop : assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !nonempty && !push) |=> !nonempty);

   a_r5_pop_moves : assert property (@(posedge clk) disable iff (!rst_n)
      (pop && nonempty && !push) |=> count == $past(count) - 1'b1);

endmodule

// File: rtl/mspkt_encoder.sv
module mspkt_encoder
   import mspkt_pkg::*;
#(
   parameter int MOT_W      = 10,
   parameter int FIFO_DEPTH = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_valid,
   input  logic [MOT_W-1:0] evt_dx,
   input  logic [MOT_W-1:0] evt_dy,
   input  logic             btn_left,
   input  logic             btn_middle,
   input  logic             btn_right,
   output logic             evt_reject,
   output logic             busy,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic             rd_nonempty
);

   localparam int CW = $clog2(FIFO_DEPTH + 1);

   generate
      if (MOT_W < 8) begin : g_bad_width
         $error("mspkt_encoder: MOT_W must be at least 8");
      end
      if (FIFO_DEPTH < PKT_BYTES) begin : g_bad_depth
         $error("mspkt_encoder: FIFO_DEPTH must hold one packet");
      end
   endgenerate

   pkt_t          pkt_new;
   logic          accept;
   logic          push;
   byte_t         push_byte;
   logic [CW-1:0] free_slots;

   assign pkt_new.hdr = HDR_BASE ^ {5'b0, btn_left, btn_middle, btn_right};

   mspkt_sat #(.IN_W(MOT_W), .NEGATE(1'b0)) u_sat_x (
      .raw (evt_dx),
      .sat (pkt_new.mx)
   );

   mspkt_sat #(.IN_W(MOT_W), .NEGATE(1'b1)) u_sat_y (
      .raw (evt_dy),
      .sat (pkt_new.my)
   );

   assign accept = evt_valid && !busy && (free_slots >= CW'(PKT_BYTES));

   mspkt_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .pkt_in    (pkt_new),
      .busy      (busy),
      .push      (push),
      .push_byte (push_byte)
   );

   mspkt_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .wdata      (push_byte),
      .pop        (rd_en),
      .rdata      (rd_data),
      .nonempty   (rd_nonempty),
      .free_slots (free_slots)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_reject <= 1'b0;
      end else begin
         evt_reject <= evt_valid && !accept;
      end
   end

   a_r7_reject_busy : assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid && busy) |=> evt_reject);

   a_r7_room_on_start : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(free_slots) >= CW'(PKT_BYTES));

   a_r7_no_reject_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid |=> !evt_reject);

endmodule

// File: tb/mspkt_encoder_test.sv
`timescale 1ns/1ps
module mspkt_encoder_test;

   localparam int    MOT_W  = 10;
   localparam int    DEPTH  = 256;
   localparam real   HALF   = 2.5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             evt_valid = 1'b0;
   logic [MOT_W-1:0] evt_dx = '0;
   logic [MOT_W-1:0] evt_dy = '0;
   logic             btn_left = 1'b0, btn_middle = 1'b0, btn_right = 1'b0;
   logic             evt_reject, busy, rd_nonempty;
   logic             rd_en = 1'b0;
   logic [7:0]       rd_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit mon_en = 1'b0;

   always #(HALF) clk = ~clk;

   mspkt_encoder #(.MOT_W(MOT_W), .FIFO_DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_dx(evt_dx),
      .evt_dy(evt_dy), .btn_left(btn_left), .btn_middle(btn_middle),
      .btn_right(btn_right), .evt_reject(evt_reject), .busy(busy),
      .rd_en(rd_en), .rd_data(rd_data), .rd_nonempty(rd_nonempty)
   );

   function automatic int sat127(int v);
      if (v > 127) return 127;
      if (v < -127) return -127;
      return v;
   endfunction

   function automatic logic [7:0] exp_byte(int dx, int dy, bit l, bit m, bit r, int k);
      int v;
      case (k)
         0: return 8'h87 ^ {5'b0, l, m, r};
         1: begin v = sat127(dx);  return v[7:0]; end
         2: begin v = sat127(-dy); return v[7:0]; end
         default: return 8'h00;
      endcase
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model, updated on the same edges as the design
   logic [7:0] m_q [DEPTH];
   logic [7:0] m_pkt [5];
   int  m_cnt, m_head, m_tail, m_busy;
   bit  m_rej, m_acc;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_head = 0; m_tail = 0; m_busy = 0; m_rej = 0;
      end else begin
         m_acc = evt_valid && (m_busy == 0) && ((DEPTH - m_cnt) >= 5);
         if (rd_en && m_cnt > 0) begin
            m_head = (m_head + 1) % DEPTH;
            m_cnt--;
         end
         if (m_busy > 0) begin
            m_q[m_tail] = m_pkt[5 - m_busy];
            m_tail = (m_tail + 1) % DEPTH;
            m_cnt++;
            m_busy--;
         end
         m_rej = evt_valid && !m_acc;
         if (m_acc) begin
            for (int k = 0; k < 5; k++)
               m_pkt[k] = exp_byte(int'($signed(evt_dx)), int'($signed(evt_dy)),
                                   btn_left, btn_middle, btn_right, k);
            m_busy = 5;
         end
      end
   end

   always @(negedge clk) begin
      if (mon_en && rst_n) begin
         check(busy == (m_busy != 0), "R6 busy", busy, m_busy != 0);
         check(evt_reject == m_rej, "R7 reject", evt_reject, m_rej);
         check(rd_nonempty == (m_cnt != 0), "R8 nonempty", rd_nonempty, m_cnt != 0);
         if (m_cnt != 0)
            check(rd_data == m_q[m_head], "R5 head byte", rd_data, m_q[m_head]);
      end
   end

   task automatic send(int dx, int dy, bit l, bit m, bit r, output bit rej, output bit bsy);
      @(negedge clk);
      evt_valid = 1'b1; evt_dx = MOT_W'(dx); evt_dy = MOT_W'(dy);
      btn_left = l; btn_middle = m; btn_right = r;
      @(negedge clk);
      evt_valid = 1'b0;
      rej = evt_reject;
      bsy = busy;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic read_expect(logic [7:0] exp, string tag);
      @(negedge clk);
      check(rd_nonempty && rd_data == exp, tag, rd_data, exp);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic read_any();
      @(negedge clk);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(HALF * 2.0 * 150000.0);
      errors++;
      $display("FAIL watchdog R6 actual=hung expected=complete");
      finish_run();
   end

   initial begin
      bit rej, bsy;
      int n;
      void'($urandom(32'd1234));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      check(!busy, "R9 busy after reset", busy, 0);
      check(!evt_reject, "R9 reject after reset", evt_reject, 0);
      check(!rd_nonempty, "R9 nonempty after reset", rd_nonempty, 0);
      mon_en = 1'b1;

      // R1 R4: no buttons, no motion; R6 busy length
      send(0, 0, 0, 0, 0, rej, bsy);
      n = 0;
      while (busy && n < 20) begin n++; @(negedge clk); end
      check(n == 5, "R6 busy cycles", n, 5);
      read_expect(8'h87, "R1 idle header");
      read_expect(8'h00, "R2 zero dx");
      read_expect(8'h00, "R3 zero dy");
      read_expect(8'h00, "R4 pad 1");
      read_expect(8'h00, "R4 pad 2");

      // R1 R2 R3: left pressed, dx over range, small negative dy
      send(200, -5, 1, 0, 0, rej, bsy); settle();
      read_expect(8'h83, "R1 left header");
      read_expect(8'h7F, "R2 dx +200 saturates");
      read_expect(8'h05, "R3 dy -5 negated");
      read_expect(8'h00, "R4 pad 1");
      read_expect(8'h00, "R4 pad 2");

      send(-300, 127, 1, 1, 1, rej, bsy); settle();
      read_expect(8'h80, "R1 all pressed");
      read_expect(8'h81, "R2 dx -300 saturates");
      read_expect(8'h81, "R3 dy +127 negated");
      read_any(); read_any();

      send(-128, -512, 0, 1, 0, rej, bsy); settle();
      read_expect(8'h85, "R1 middle header");
      read_expect(8'h81, "R2 dx -128 saturates");
      read_expect(8'h7F, "R3 dy -512 negated saturates");
      read_any(); read_any();

      send(127, -128, 0, 0, 1, rej, bsy); settle();
      read_expect(8'h86, "R1 right header");
      read_expect(8'h7F, "R2 dx +127 passes");
      read_expect(8'h7F, "R3 dy -128 negated saturates");
      read_any(); read_any();

      // R7: second event while busy is refused and adds nothing
      @(negedge clk);
      evt_valid = 1'b1; evt_dx = MOT_W'(3); evt_dy = MOT_W'(4);
      btn_left = 0; btn_middle = 0; btn_right = 0;
      @(negedge clk);
      evt_dx = MOT_W'(99); evt_dy = MOT_W'(99);
      @(negedge clk);
      evt_valid = 1'b0;
      check(evt_reject, "R7 reject while busy", evt_reject, 1);
      settle();
      read_expect(8'h87, "R7 kept packet header");
      read_expect(8'h03, "R7 kept packet dx");
      read_expect(8'hFC, "R7 kept packet dy");
      read_any(); read_any();
      @(negedge clk);
      check(!rd_nonempty, "R7 refused event added no byte", rd_nonempty, 0);

      // R5: read strobe on empty FIFO is ignored
      @(negedge clk); rd_en = 1'b1;
      repeat (3) @(negedge clk);
      rd_en = 1'b0;
      check(!rd_nonempty, "R5 empty read ignored", rd_nonempty, 0);
      send(10, 20, 0, 0, 0, rej, bsy); settle();
      read_expect(8'h87, "R5 order after empty read");
      read_expect(8'h0A, "R5 dx after empty read");
      read_expect(8'hEC, "R5 dy after empty read");
      read_any(); read_any();

      // R8: fill to 255 bytes, then the space boundary
      for (int p = 0; p < 51; p++) begin
         send(p, -p, p[0], p[1], p[2], rej, bsy);
         settle();
      end
      send(1, 1, 0, 0, 0, rej, bsy);
      check(rej, "R8 refused with 1 free slot", rej, 1);
      read_any(); read_any(); read_any();
      send(1, 1, 0, 0, 0, rej, bsy);
      check(rej, "R7 refused with 4 free slots", rej, 1);
      read_any();
      send(1, 1, 0, 0, 0, rej, bsy);
      check(!rej && bsy, "R7 accepted with 5 free slots", {rej, bsy}, 1);
      settle();
      while (rd_nonempty) read_any();
      check(!rd_nonempty, "R8 drained", rd_nonempty, 0);

      // random phases
      for (int c = 0; c < 6000; c++) begin
         @(negedge clk);
         evt_valid  = ($urandom_range(0, 3) == 0);
         evt_dx     = MOT_W'($urandom_range(0, (1 << MOT_W) - 1));
         evt_dy     = MOT_W'($urandom_range(0, (1 << MOT_W) - 1));
         btn_left   = $urandom_range(0, 1) == 1;
         btn_middle = $urandom_range(0, 1) == 1;
         btn_right  = $urandom_range(0, 1) == 1;
         if (((c / 800) % 2) == 0) rd_en = ($urandom_range(0, 9) == 0);
         else                      rd_en = ($urandom_range(0, 9) < 8);
      end
      @(negedge clk);
      evt_valid = 1'b0; rd_en = 1'b0;
      repeat (8) @(negedge clk);
      finish_run();
   end

endmodule